// File: doc/BRIEF.md
# Multicore Thread Park Control Registers

This block is a small bank of control masks for a cluster of eight virtual cores (hardware threads). A privileged software thread reaches it through a plain load/store register port. Each port transaction carries a request strobe, a read/write flag, a 4-bit register select, 64-bit write data and the ID of the thread that makes the request. Read data and an error flag come back one clock after the request. Every mask holds one bit per core. Bits above the core count always read as zero.

The bank holds a fixed availability mask, an enable request, an enable status, a running (unparked) mask, a registered running status and an external-reset steering mask. The running mask can be written three ways: directly, through a set-only alias, and through a clear-only alias. Every writable mask is gated by availability. An enable request takes effect only when a warm reset pulse arrives. A thread can never clear its own enable bit. The registered running status drives the per-core run/park output vector, where 1 means run and 0 means park.

Top module: `core_park_regs`

## Requirements
- R1: Select 0 reads the availability mask, a build-time constant that defaults to 0xFF and is zero-extended. A write to select 0 changes nothing.
- R2: Select 1 (enable request) is read/write. Select 2 (enable status) is read-only and changes only on a warm reset pulse, when it takes the enable request value.
- R3: In the enable request, running and steering masks, bits for unavailable cores and bits 63 to 8 read back as 0.
- R4: A write to select 1 always leaves the bit of the requesting thread (req_tid) set, if that core is available.
- R5: Select 3 is the running mask, with 1 meaning active and 0 meaning parked. A direct write of all ones reads back as the availability mask.
- R6: A write to select 4 sets every running bit written as 1 and leaves all other bits unchanged.
- R7: A write to select 5 clears every running bit written as 1 and leaves all other bits unchanged.
- R8: Select 6 and the run_vec output give the running status, which is running AND enable status. It updates one clock after the running mask or enable status changes.
- R9: Select 7 is the external-reset steering mask. It is read/write and masked by availability, so a write of 0 reads back as 0.
- R10: Asynchronous reset sets the enable request, enable status, running mask, running status and steering mask to the availability mask, and clears rsp_rdata and rsp_err.
- R11: A warm_rst pulse loads the enable status and running mask from the enable request and sets the steering mask to availability. The enable request keeps its value. A warm reset wins over a running or steering write in the same cycle.
- R12: An access to select 8 to 15 returns rsp_rdata 0, raises rsp_err for that one response only, and changes no mask.
- R13: A read of select 4 or select 5 returns the running mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warm_rst | input | 1 | Synchronous warm reset pulse that applies the enable request |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 4 | Register select |
| req_wdata | input | 64 | Write data |
| req_tid | input | 3 | ID of the requesting thread |
| rsp_rdata | output | 64 | Read data, one clock after the request |
| rsp_err | output | 1 | Unknown-select flag, one clock after the request |
| run_vec | output | 8 | Per-core run (1) / park (0) |

## Verification
A warm reset pulse and a software write to the running mask can land on the same clock edge. The bench provokes this by raising warm_rst in the same cycle as a direct write of zero to select 3, after the enable request has been set to all ones. It then reads the running mask and the enable status and expects both to hold the enable request value, with the write discarded. It also samples run_vec on the edge right after each running-mask change and again one edge later. The first sample must show the old status and the second must show the new one.

// File: rtl/park_pkg.sv
package park_pkg;

  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_AVAIL    = 4'd0,
    SEL_EN_REQ   = 4'd1,
    SEL_EN_STAT  = 4'd2,
    SEL_RUN      = 4'd3,
    SEL_RUN_SET  = 4'd4,
    SEL_RUN_CLR  = 4'd5,
    SEL_RUN_STAT = 4'd6,
    SEL_STEER    = 4'd7
  } park_sel_e;

  typedef struct packed {
    logic      rd;
    logic      bad;
    logic      wr_en_req;
    logic      wr_run;
    logic      wr_run_set;
    logic      wr_run_clr;
    logic      wr_steer;
    park_sel_e sel;
  } park_dec_t;

endpackage

// File: rtl/park_decode.sv
module park_decode
  import park_pkg::*;
(
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [SEL_W-1:0] req_sel,
  output park_dec_t        dec
);

  logic known;
  logic wr_go;

  // Selects 8..15 carry the top select bit and hit no register
  assign known = ~req_sel[SEL_W-1];
  assign wr_go = req_valid & req_write & known;

  always_comb begin
    dec            = '0;
    dec.sel        = park_sel_e'(req_sel);
    dec.rd         = req_valid & ~req_write & known;
    dec.bad        = req_valid & ~known;
    dec.wr_en_req  = wr_go & (req_sel == SEL_EN_REQ);
    dec.wr_run     = wr_go & (req_sel == SEL_RUN);
    dec.wr_run_set = wr_go & (req_sel == SEL_RUN_SET);
    dec.wr_run_clr = wr_go & (req_sel == SEL_RUN_CLR);
    dec.wr_steer   = wr_go & (req_sel == SEL_STEER);
  end

endmodule

// File: rtl/park_masks.sv
module park_masks
  import park_pkg::*;
#(
  parameter int                    NUM_CORES  = 8,
  parameter logic [NUM_CORES-1:0]  AVAIL_MASK = {NUM_CORES{1'b1}},
  localparam int                   TID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 warm_rst,
  input  park_dec_t            dec,
  input  logic [NUM_CORES-1:0] wdata,
  input  logic [TID_W-1:0]     req_tid,
  output logic [NUM_CORES-1:0] en_req_q,
  output logic [NUM_CORES-1:0] en_stat_q,
  output logic [NUM_CORES-1:0] run_q,
  output logic [NUM_CORES-1:0] steer_q
);

  logic [NUM_CORES-1:0] en_req_d;
  logic [NUM_CORES-1:0] run_d;
  logic [NUM_CORES-1:0] steer_d;
  logic                 en_req_en;
  logic                 en_stat_en;
  logic                 run_en;
  logic                 steer_en;

  assign en_req_en  = dec.wr_en_req;
  assign en_stat_en = warm_rst;
  assign run_en     = warm_rst | dec.wr_run | dec.wr_run_set | dec.wr_run_clr;
  assign steer_en   = warm_rst | dec.wr_steer;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic self_hit;
    assign self_hit    = (req_tid == TID_W'(i));
    // The requesting thread cannot drop its own enable
    assign en_req_d[i] = (wdata[i] | self_hit) & AVAIL_MASK[i];
    // Warm reset has priority over any software write to the running mask
    assign run_d[i]    = warm_rst       ? en_req_q[i] :
                         dec.wr_run     ? (wdata[i] & AVAIL_MASK[i]) :
                         dec.wr_run_set ? ((run_q[i] | wdata[i]) & AVAIL_MASK[i]) :
                         dec.wr_run_clr ? (run_q[i] & ~wdata[i]) :
                                          run_q[i];
    assign steer_d[i]  = warm_rst ? AVAIL_MASK[i] : (wdata[i] & AVAIL_MASK[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req_q  <= AVAIL_MASK;
      en_stat_q <= AVAIL_MASK;
      run_q     <= AVAIL_MASK;
      steer_q   <= AVAIL_MASK;
    end else begin
      if (en_req_en)  en_req_q  <= en_req_d;
      if (en_stat_en) en_stat_q <= en_req_q;
      if (run_en)     run_q     <= run_d;
      if (steer_en)   steer_q   <= steer_d;
    end
  end

  AST_SELF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec.wr_en_req |=> en_req_q[$past(req_tid)] == AVAIL_MASK[$past(req_tid)]); // R4

  AST_ENSTAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst |=> $stable(en_stat_q)); // R2

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.wr_run_clr && !warm_rst) |=> (run_q & $past(wdata)) == '0); // R7

  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.wr_run_set && !warm_rst) |=> ($past(run_q) & ~run_q) == '0); // R6

endmodule

// File: rtl/park_status.sv
module park_status #(
  parameter int                   NUM_CORES  = 8,
  parameter logic [NUM_CORES-1:0] AVAIL_MASK = {NUM_CORES{1'b1}}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] run_q,
  input  logic [NUM_CORES-1:0] en_stat_q,
  output logic [NUM_CORES-1:0] run_stat_q
);

  logic [NUM_CORES-1:0] run_stat_d;

  assign run_stat_d = run_q & en_stat_q & AVAIL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_stat_q <= AVAIL_MASK;
    else        run_stat_q <= run_stat_d;
  end

  AST_PARK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (run_stat_q & ~$past(run_q)) == '0); // R8

endmodule

// File: rtl/park_resp.sv
module park_resp
  import park_pkg::*;
#(
  parameter int                   NUM_CORES  = 8,
  parameter int                   DATA_W     = 64,
  parameter logic [NUM_CORES-1:0] AVAIL_MASK = {NUM_CORES{1'b1}}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  park_dec_t            dec,
  input  logic [NUM_CORES-1:0] en_req_q,
  input  logic [NUM_CORES-1:0] en_stat_q,
  input  logic [NUM_CORES-1:0] run_q,
  input  logic [NUM_CORES-1:0] run_stat_q,
  input  logic [NUM_CORES-1:0] steer_q,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err
);

  logic [NUM_CORES-1:0] mux_bits;
  logic [DATA_W-1:0]    rdata_d;
  logic                 rdata_en;

  always_comb begin
    unique case (dec.sel)
      SEL_AVAIL:    mux_bits = AVAIL_MASK;
      SEL_EN_REQ:   mux_bits = en_req_q;
      SEL_EN_STAT:  mux_bits = en_stat_q;
      SEL_RUN,
      SEL_RUN_SET,
      SEL_RUN_CLR:  mux_bits = run_q;
      SEL_RUN_STAT: mux_bits = run_stat_q;
      SEL_STEER:    mux_bits = steer_q;
      default:      mux_bits = '0;
    endcase
  end

  assign rdata_en = dec.rd | dec.bad;
  assign rdata_d  = dec.bad ? '0 : DATA_W'(mux_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (rdata_en) rsp_rdata <= rdata_d;
      rsp_err <= dec.bad;
    end
  end

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == '0); // R12

endmodule

// File: rtl/core_park_regs.sv
module core_park_regs
  import park_pkg::*;
#(
  parameter int                   NUM_CORES  = 8,
  parameter int                   DATA_W     = 64,
  parameter logic [NUM_CORES-1:0] AVAIL_MASK = {NUM_CORES{1'b1}},
  localparam int                  TID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 warm_rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [SEL_W-1:0]     req_sel,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [TID_W-1:0]     req_tid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_CORES-1:0] run_vec
);

  park_dec_t            dec;
  logic [NUM_CORES-1:0] en_req_q;
  logic [NUM_CORES-1:0] en_stat_q;
  logic [NUM_CORES-1:0] run_q;
  logic [NUM_CORES-1:0] steer_q;
  logic [NUM_CORES-1:0] run_stat_q;

  if (NUM_CORES < DATA_W) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^req_wdata[DATA_W-1:NUM_CORES];
  end

  park_decode u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .dec       (dec)
  );

  park_masks #(
    .NUM_CORES  (NUM_CORES),
    .AVAIL_MASK (AVAIL_MASK)
  ) u_masks (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .dec       (dec),
    .wdata     (req_wdata[NUM_CORES-1:0]),
    .req_tid   (req_tid),
    .en_req_q  (en_req_q),
    .en_stat_q (en_stat_q),
    .run_q     (run_q),
    .steer_q   (steer_q)
  );

  park_status #(
    .NUM_CORES  (NUM_CORES),
    .AVAIL_MASK (AVAIL_MASK)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_q      (run_q),
    .en_stat_q  (en_stat_q),
    .run_stat_q (run_stat_q)
  );

  park_resp #(
    .NUM_CORES  (NUM_CORES),
    .DATA_W     (DATA_W),
    .AVAIL_MASK (AVAIL_MASK)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec        (dec),
    .en_req_q   (en_req_q),
    .en_stat_q  (en_stat_q),
    .run_q      (run_q),
    .run_stat_q (run_stat_q),
    .steer_q    (steer_q),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err)
  );

  assign run_vec = run_stat_q;

  AST_WARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> run_q == en_stat_q); // R11

endmodule

// File: tb/sim_core_park_regs.sv
`timescale 1ns/1ps
module sim_core_park_regs;

  localparam int NV = 28;
  // {wr, sel[3:0], wdata[63:0], tid[2:0], exp_rdata[63:0], exp_err}
  localparam logic [136:0] VEC [NV] = '{
    {1'b0, 4'd0, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R1
    {1'b1, 4'd0, 64'h0,                  3'd0, 64'h0,  1'b0}, // R1 write ignored
    {1'b0, 4'd0, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R1
    {1'b0, 4'd2, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R10
    {1'b0, 4'd3, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R10
    {1'b0, 4'd7, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R10
    {1'b1, 4'd1, 64'h5555555555555555,   3'd0, 64'h0,  1'b0}, // R3
    {1'b0, 4'd1, 64'h0,                  3'd0, 64'h55, 1'b0}, // R3
    {1'b1, 4'd1, 64'h0,                  3'd2, 64'h0,  1'b0}, // R4
    {1'b0, 4'd1, 64'h0,                  3'd0, 64'h04, 1'b0}, // R4
    {1'b0, 4'd2, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R2
    {1'b1, 4'd3, 64'hFFFFFFFFFFFFFFFF,   3'd0, 64'h0,  1'b0}, // R5
    {1'b0, 4'd3, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R5
    {1'b1, 4'd3, 64'h0F000000000000A5,   3'd0, 64'h0,  1'b0}, // R3
    {1'b0, 4'd3, 64'h0,                  3'd0, 64'hA5, 1'b0}, // R3
    {1'b1, 4'd4, 64'h0A,                 3'd0, 64'h0,  1'b0}, // R6
    {1'b0, 4'd3, 64'h0,                  3'd0, 64'hAF, 1'b0}, // R6
    {1'b1, 4'd5, 64'hFFFFFFFFFFFFFFF0,   3'd0, 64'h0,  1'b0}, // R7
    {1'b0, 4'd3, 64'h0,                  3'd0, 64'h0F, 1'b0}, // R7
    {1'b0, 4'd4, 64'h0,                  3'd0, 64'h0F, 1'b0}, // R13
    {1'b0, 4'd6, 64'h0,                  3'd0, 64'h0F, 1'b0}, // R8
    {1'b1, 4'd7, 64'hFFFFFFFFFFFFFFFF,   3'd0, 64'h0,  1'b0}, // R9
    {1'b0, 4'd7, 64'h0,                  3'd0, 64'hFF, 1'b0}, // R9
    {1'b1, 4'd7, 64'h0,                  3'd0, 64'h0,  1'b0}, // R9
    {1'b0, 4'd7, 64'h0,                  3'd0, 64'h0,  1'b0}, // R9
    {1'b1, 4'd9, 64'hFF,                 3'd0, 64'h0,  1'b1}, // R12
    {1'b0, 4'd15, 64'h0,                 3'd0, 64'h0,  1'b1}, // R12
    {1'b0, 4'd3, 64'h0,                  3'd0, 64'h0F, 1'b0}  // R12 no change
  };

  logic        clk;
  logic        rst_n;
  logic        warm_rst;
  logic        req_valid;
  logic        req_write;
  logic [3:0]  req_sel;
  logic [63:0] req_wdata;
  logic [2:0]  req_tid;
  logic [63:0] rsp_rdata;
  logic        rsp_err;
  logic [7:0]  run_vec;

  int n_vec;
  int n_miss;

  core_park_regs u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_wdata (req_wdata),
    .req_tid   (req_tid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .run_vec   (run_vec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic acc(input logic wr, input logic [3:0] sel, input logic [63:0] wd,
                     input logic [2:0] tid);
    req_valid = 1'b1;
    req_write = wr;
    req_sel   = sel;
    req_wdata = wd;
    req_tid   = tid;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    n_vec = 0; n_miss = 0;
    rst_n = 1'b0; warm_rst = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_sel = '0; req_wdata = '0; req_tid = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset rdata", rsp_rdata, 64'h0);
    chk("R10 reset err", {63'h0, rsp_err}, 64'h0);
    chk("R10 reset run_vec", {56'h0, run_vec}, 64'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][136], VEC[i][135:132], VEC[i][131:68], VEC[i][67:65]);
      chk($sformatf("vec %0d err", i), {63'h0, rsp_err}, {63'h0, VEC[i][0]});
      if (!VEC[i][136] || VEC[i][135])
        chk($sformatf("vec %0d rdata", i), rsp_rdata, VEC[i][64:1]);
    end

    // Warm reset alone: enreq=04, run=0F, steer=0 before the pulse
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    chk("R8 run_vec lags warm", {56'h0, run_vec}, 64'h0F);
    @(negedge clk);
    chk("R11 run_vec after warm", {56'h0, run_vec}, 64'h04);
    acc(1'b0, 4'd2, 64'h0, 3'd0); chk("R2 en stat after warm", rsp_rdata, 64'h04);
    acc(1'b0, 4'd1, 64'h0, 3'd0); chk("R11 en req kept", rsp_rdata, 64'h04);
    acc(1'b0, 4'd7, 64'h0, 3'd0); chk("R11 steer to avail", rsp_rdata, 64'hFF);
    acc(1'b0, 4'd3, 64'h0, 3'd0); chk("R11 run from req", rsp_rdata, 64'h04);

    // Park timing
    acc(1'b1, 4'd3, 64'h0, 3'd0);
    chk("R8 park lag", {56'h0, run_vec}, 64'h04);
    @(negedge clk);
    chk("R8 parked", {56'h0, run_vec}, 64'h00);
    acc(1'b1, 4'd4, 64'hFF, 3'd0);
    chk("R8 set lag", {56'h0, run_vec}, 64'h00);
    @(negedge clk);
    chk("R8 enable gates status", {56'h0, run_vec}, 64'h04);

    // Warm reset colliding with a running-mask write
    acc(1'b1, 4'd1, 64'hFF, 3'd0);
    warm_rst = 1'b1;
    acc(1'b1, 4'd3, 64'h0, 3'd0);
    warm_rst = 1'b0;
    acc(1'b0, 4'd3, 64'h0, 3'd0); chk("R11 warm beats write", rsp_rdata, 64'hFF);
    acc(1'b0, 4'd2, 64'h0, 3'd0); chk("R11 en stat on collide", rsp_rdata, 64'hFF);
    chk("R8 run_vec after collide", {56'h0, run_vec}, 64'hFF);

    // Error flag lasts one response
    acc(1'b0, 4'd12, 64'h0, 3'd0);
    chk("R12 err raised", {63'h0, rsp_err}, 64'h1);
    @(negedge clk);
    chk("R12 err one cycle", {63'h0, rsp_err}, 64'h0);

    // Asynchronous reset in mid-run
    acc(1'b1, 4'd3, 64'h0, 3'd0);
    acc(1'b1, 4'd1, 64'h0, 3'd0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R10 async run_vec", {56'h0, run_vec}, 64'hFF);
    chk("R10 async rdata", rsp_rdata, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    acc(1'b0, 4'd1, 64'h0, 3'd0); chk("R10 en req reset", rsp_rdata, 64'hFF);
    acc(1'b0, 4'd3, 64'h0, 3'd0); chk("R10 run reset", rsp_rdata, 64'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule